// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block controls a bank of 32 general-purpose pins. Each pin is driven either by the port itself or by one of four peripheral functions, called A, B, C and D. Software reaches the block through a word-addressed register interface. It uses a 5-bit address, 32-bit write data and a write strobe. Read data is combinational.

Most per-pin controls are changed through paired registers. One register of each pair sets bits and the other clears them. A bit written as 1 acts on its pin, and a bit written as 0 leaves that pin unchanged. Each control has a status register that reads its current state. The peripheral choice is a two-bit code spread across two plain read/write select registers.

On the pin side the block drives a pad value, a pad drive enable and the pull and Schmitt-disable controls. It samples the pad level through a two-flop synchronizer. The synchronized level goes to the level status register and to the peripherals. Pull-up and pull-down can never both be on for one pin: setting either one clears the other in the same cycle.

Top module: `gpio_mux_port`

## Requirements
- R1: Writing 1s to address 0x00 gives those pins to the port, and writing 1s to 0x01 gives them to a peripheral. Bits written as 0 are unchanged. Address 0x02 reads ownership, where 1 means port-owned.
- R2: Three controls are each written through a set/clear pair and read at a status address, with the same 1-acts and 0-ignores rule as R1. Drive enable uses 0x03 (set), 0x04 (clear) and 0x05 (status). Output data uses 0x06, 0x07 and 0x08. Multi-drive uses 0x0F, 0x10 and 0x11.
- R3: Pull-up uses 0x09 (set), 0x0A (clear) and 0x0B (status). Pull-down uses 0x0C, 0x0D and 0x0E. Setting pull-up on a pin clears its pull-down in the same cycle, and setting pull-down clears the pull-up. The two are never both 1 on a pin, and the pad_pu and pad_pd outputs mirror the status registers.
- R4: The select registers at 0x12 (sel1) and 0x13 (sel2) are read/write. For a peripheral-owned pin, the bit pair (sel1,sel2) chooses the source: (0,0) selects A, (1,0) selects B, (0,1) selects C and (1,1) selects D.
- R5: For a port-owned pin without multi-drive, pad_out equals the output-data bit and pad_oe equals the drive-enable bit.
- R6: When multi-drive is set, the pin's source value and enable come from the port registers or from the selected peripheral. The pad is then driven only while the source value is 0 and the source enable is 1. In that state pad_oe is 1 and pad_out is 0. Otherwise pad_oe is 0 and pad_out is 0.
- R7: Address 0x15 and the periph_in output return the pad level after two register stages, whatever owns the pin. A level held across two rising edges is visible after the second edge.
- R8: Address 0x14 is a read/write Schmitt-disable register, and pad_st_off mirrors it.
- R9: After reset, all pins are port-owned and pull-ups are on. Drive enable, output data, pull-downs, multi-drive, selects and Schmitt-disable are all 0.
- R10: Addresses 0x16 to 0x1F read 0. Writes to a status address (0x02, 0x05, 0x08, 0x0B, 0x0E, 0x11, 0x15) or to an unmapped address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data, one bit per pin |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Combinational read data |
| pad_in | input | 32 | Raw pad levels |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad drive enable |
| pad_pu | output | 32 | Pull-up enable |
| pad_pd | output | 32 | Pull-down enable |
| pad_st_off | output | 32 | Schmitt trigger disable |
| fa_out | input | 32 | Function A output values |
| fa_oe | input | 32 | Function A drive enables |
| fb_out | input | 32 | Function B output values |
| fb_oe | input | 32 | Function B drive enables |
| fc_out | input | 32 | Function C output values |
| fc_oe | input | 32 | Function C drive enables |
| fd_out | input | 32 | Function D output values |
| fd_oe | input | 32 | Function D drive enables |
| periph_in | output | 32 | Synchronized pad level for peripherals |

## Verification
The hardest case to reach is a peripheral-owned pin that has multi-drive on and a particular select code. For that pin, the enable and value of exactly one of four functions must decide the pad. Random register writes produce a mix of ownership, select pairs and multi-drive on different pins. The peripheral inputs are re-randomized between writes, so all four sources and all open-drain combinations appear bitwise. Directed writes also step one peripheral-owned pin through each of the four select codes.

// File: rtl/gpio_mux_pkg.sv
`timescale 1ns/1ps
package gpio_mux_pkg;
  localparam int ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_OWN_SET = 5'h00, A_OWN_CLR = 5'h01, A_OWN_ST = 5'h02,
    A_OE_SET  = 5'h03, A_OE_CLR  = 5'h04, A_OE_ST  = 5'h05,
    A_DO_SET  = 5'h06, A_DO_CLR  = 5'h07, A_DO_ST  = 5'h08,
    A_PU_SET  = 5'h09, A_PU_CLR  = 5'h0A, A_PU_ST  = 5'h0B,
    A_PD_SET  = 5'h0C, A_PD_CLR  = 5'h0D, A_PD_ST  = 5'h0E,
    A_MD_SET  = 5'h0F, A_MD_CLR  = 5'h10, A_MD_ST  = 5'h11,
    A_SEL1    = 5'h12, A_SEL2    = 5'h13, A_STOFF  = 5'h14,
    A_LEVEL   = 5'h15
  } reg_addr_e;

  // Source code: 0=A, 1=B, 2=C, 3=D; sel1 is the low bit.
  function automatic logic [1:0] src_code(input logic s1, input logic s2);
    return {s2, s1};
  endfunction

  // Returns {oe, out} for one pad given the source and open-drain mode.
  function automatic logic [1:0] pad_drive(input logic od, input logic val,
                                           input logic en);
    if (od) return {en & ~val, 1'b0};
    return {en, val};
  endfunction
endpackage

// File: rtl/gpio_wsc_reg.sv
`timescale 1ns/1ps
module gpio_wsc_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= (q & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
  parameter int W = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pad_mux.sv
`timescale 1ns/1ps
module gpio_pad_mux
  import gpio_mux_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] own,
  input  logic [W-1:0] oe,
  input  logic [W-1:0] dout,
  input  logic [W-1:0] md,
  input  logic [W-1:0] sel1,
  input  logic [W-1:0] sel2,
  input  logic [W-1:0] fa_out,
  input  logic [W-1:0] fa_oe,
  input  logic [W-1:0] fb_out,
  input  logic [W-1:0] fb_oe,
  input  logic [W-1:0] fc_out,
  input  logic [W-1:0] fc_oe,
  input  logic [W-1:0] fd_out,
  input  logic [W-1:0] fd_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [1:0] code;
    logic       p_val, p_en, s_val, s_en;
    logic [1:0] drv;

    assign code = src_code(sel1[i], sel2[i]);

    always_comb begin
      unique case (code)
        2'd0: begin p_val = fa_out[i]; p_en = fa_oe[i]; end
        2'd1: begin p_val = fb_out[i]; p_en = fb_oe[i]; end
        2'd2: begin p_val = fc_out[i]; p_en = fc_oe[i]; end
        default: begin p_val = fd_out[i]; p_en = fd_oe[i]; end
      endcase
    end

    assign s_val = own[i] ? dout[i] : p_val;
    assign s_en  = own[i] ? oe[i]   : p_en;
    assign drv   = pad_drive(md[i], s_val, s_en);
    assign pad_oe[i]  = drv[1];
    assign pad_out[i] = drv[0];
  end
endmodule

// File: rtl/gpio_mux_port.sv
`timescale 1ns/1ps
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPINS-1:0]  reg_wdata,
  input  logic              reg_we,
  output logic [NPINS-1:0]  reg_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pu,
  output logic [NPINS-1:0]  pad_pd,
  output logic [NPINS-1:0]  pad_st_off,
  input  logic [NPINS-1:0]  fa_out,
  input  logic [NPINS-1:0]  fa_oe,
  input  logic [NPINS-1:0]  fb_out,
  input  logic [NPINS-1:0]  fb_oe,
  input  logic [NPINS-1:0]  fc_out,
  input  logic [NPINS-1:0]  fc_oe,
  input  logic [NPINS-1:0]  fd_out,
  input  logic [NPINS-1:0]  fd_oe,
  output logic [NPINS-1:0]  periph_in
);
  localparam logic [NPINS-1:0] ALL1 = {NPINS{1'b1}};
  localparam logic [NPINS-1:0] ALL0 = '0;

  // Decoded write masks, named for the checker.
  logic [NPINS-1:0] own_set, own_clr, oe_set, oe_clr, do_set, do_clr;
  logic [NPINS-1:0] pu_set, pu_clr, pd_set, pd_clr, md_set, md_clr;
  logic [NPINS-1:0] own_q, oe_q, do_q, pu_q, pd_q, md_q;
  logic [NPINS-1:0] sel1_q, sel2_q, stoff_q, lvl_q;

  function automatic logic [NPINS-1:0] wmask(input logic we,
      input logic [ADDR_W-1:0] a, input reg_addr_e tgt,
      input logic [NPINS-1:0] d);
    return (we && a == tgt) ? d : '0;
  endfunction

  assign own_set = wmask(reg_we, reg_addr, A_OWN_SET, reg_wdata);
  assign own_clr = wmask(reg_we, reg_addr, A_OWN_CLR, reg_wdata);
  assign oe_set  = wmask(reg_we, reg_addr, A_OE_SET,  reg_wdata);
  assign oe_clr  = wmask(reg_we, reg_addr, A_OE_CLR,  reg_wdata);
  assign do_set  = wmask(reg_we, reg_addr, A_DO_SET,  reg_wdata);
  assign do_clr  = wmask(reg_we, reg_addr, A_DO_CLR,  reg_wdata);
  assign pu_set  = wmask(reg_we, reg_addr, A_PU_SET,  reg_wdata);
  assign pu_clr  = wmask(reg_we, reg_addr, A_PU_CLR,  reg_wdata);
  assign pd_set  = wmask(reg_we, reg_addr, A_PD_SET,  reg_wdata);
  assign pd_clr  = wmask(reg_we, reg_addr, A_PD_CLR,  reg_wdata);
  assign md_set  = wmask(reg_we, reg_addr, A_MD_SET,  reg_wdata);
  assign md_clr  = wmask(reg_we, reg_addr, A_MD_CLR,  reg_wdata);

  gpio_wsc_reg #(.W(NPINS), .RST_VAL(ALL1)) u_own (.clk(clk), .rst_n(rst_n),
    .set_mask(own_set), .clr_mask(own_clr), .q(own_q));
  gpio_wsc_reg #(.W(NPINS), .RST_VAL(ALL0)) u_oe (.clk(clk), .rst_n(rst_n),
    .set_mask(oe_set), .clr_mask(oe_clr), .q(oe_q));
  gpio_wsc_reg #(.W(NPINS), .RST_VAL(ALL0)) u_do (.clk(clk), .rst_n(rst_n),
    .set_mask(do_set), .clr_mask(do_clr), .q(do_q));
  // Cross-clear: a set of one pull type clears the other.
  gpio_wsc_reg #(.W(NPINS), .RST_VAL(ALL1)) u_pu (.clk(clk), .rst_n(rst_n),
    .set_mask(pu_set), .clr_mask(pu_clr | pd_set), .q(pu_q));
  gpio_wsc_reg #(.W(NPINS), .RST_VAL(ALL0)) u_pd (.clk(clk), .rst_n(rst_n),
    .set_mask(pd_set), .clr_mask(pd_clr | pu_set), .q(pd_q));
  gpio_wsc_reg #(.W(NPINS), .RST_VAL(ALL0)) u_md (.clk(clk), .rst_n(rst_n),
    .set_mask(md_set), .clr_mask(md_clr), .q(md_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel1_q  <= '0;
      sel2_q  <= '0;
      stoff_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_SEL1)  sel1_q  <= reg_wdata;
      if (reg_addr == A_SEL2)  sel2_q  <= reg_wdata;
      if (reg_addr == A_STOFF) stoff_q <= reg_wdata;
    end
  end

  gpio_pin_sync #(.W(NPINS), .STAGES(2)) u_sync (.clk(clk), .rst_n(rst_n),
    .d(pad_in), .q(lvl_q));

  gpio_pad_mux #(.W(NPINS)) u_mux (
    .own(own_q), .oe(oe_q), .dout(do_q), .md(md_q),
    .sel1(sel1_q), .sel2(sel2_q),
    .fa_out(fa_out), .fa_oe(fa_oe), .fb_out(fb_out), .fb_oe(fb_oe),
    .fc_out(fc_out), .fc_oe(fc_oe), .fd_out(fd_out), .fd_oe(fd_oe),
    .pad_out(pad_out), .pad_oe(pad_oe));

  always_comb begin
    case (reg_addr)
      A_OWN_ST: reg_rdata = own_q;
      A_OE_ST:  reg_rdata = oe_q;
      A_DO_ST:  reg_rdata = do_q;
      A_PU_ST:  reg_rdata = pu_q;
      A_PD_ST:  reg_rdata = pd_q;
      A_MD_ST:  reg_rdata = md_q;
      A_SEL1:   reg_rdata = sel1_q;
      A_SEL2:   reg_rdata = sel2_q;
      A_STOFF:  reg_rdata = stoff_q;
      A_LEVEL:  reg_rdata = lvl_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign pad_pu     = pu_q;
  assign pad_pd     = pd_q;
  assign pad_st_off = stoff_q;
  assign periph_in  = lvl_q;
endmodule

// File: rtl/gpio_mux_port_chk.sv
`timescale 1ns/1ps
module gpio_mux_port_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [4:0]       reg_addr,
  input logic [NPINS-1:0] reg_wdata,
  input logic [NPINS-1:0] own_q,
  input logic [NPINS-1:0] oe_q,
  input logic [NPINS-1:0] pu_q,
  input logic [NPINS-1:0] pd_q,
  input logic [NPINS-1:0] md_q,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] lvl_q,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_out
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  a_r1_own_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 5'h00) |=> ((own_q & $past(reg_wdata)) == $past(reg_wdata)));

  a_r2_oe_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 5'h04) |=> ((oe_q & $past(reg_wdata)) == '0));

  a_r3_pull_excl: assert property (@(posedge clk) disable iff (!rst_n)
    ((pu_q & pd_q) == '0));

  a_r6_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
    ((md_q & pad_out) == '0));

  a_r7_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (lvl_q == $past(pad_in, 2)));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(own_q) && $stable(oe_q) && $stable(md_q)
                 && $stable(pu_q) && $stable(pd_q)));

  a_r5_port_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ((own_q & ~md_q & (pad_oe ^ oe_q)) == '0));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .own_q(own_q), .oe_q(oe_q), .pu_q(pu_q),
  .pd_q(pd_q), .md_q(md_q), .pad_in(pad_in), .lvl_q(lvl_q),
  .pad_oe(pad_oe), .pad_out(pad_out));

// File: tb/gpio_mux_port_tb_top.sv
`timescale 1ns/1ps
module gpio_mux_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pad_pu, pad_pd, pad_st_off, periph_in;
  logic [31:0] fa_out = '0, fa_oe = '0, fb_out = '0, fb_oe = '0;
  logic [31:0] fc_out = '0, fc_oe = '0, fd_out = '0, fd_oe = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  gpio_mux_port dut_i (.*);

  // Bench model of the register state.
  logic [31:0] m_own, m_oe, m_do, m_pu, m_pd, m_md, m_s1, m_s2, m_st;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] src_val();
    logic [31:0] a, b, c, d;
    a = ~m_s1 & ~m_s2; b = m_s1 & ~m_s2; c = ~m_s1 & m_s2; d = m_s1 & m_s2;
    return (m_own & m_do) |
           (~m_own & ((a & fa_out) | (b & fb_out) | (c & fc_out) | (d & fd_out)));
  endfunction

  function automatic logic [31:0] src_en();
    logic [31:0] a, b, c, d;
    a = ~m_s1 & ~m_s2; b = m_s1 & ~m_s2; c = ~m_s1 & m_s2; d = m_s1 & m_s2;
    return (m_own & m_oe) |
           (~m_own & ((a & fa_oe) | (b & fb_oe) | (c & fc_oe) | (d & fd_oe)));
  endfunction

  function automatic logic [31:0] exp_oe();
    return src_en() & ~(m_md & src_val());
  endfunction

  function automatic logic [31:0] exp_out();
    return src_val() & ~m_md;
  endfunction

  task automatic model_write(input logic [4:0] a, input logic [31:0] d);
    case (a)
      5'h00: m_own |= d;  5'h01: m_own &= ~d;
      5'h03: m_oe  |= d;  5'h04: m_oe  &= ~d;
      5'h06: m_do  |= d;  5'h07: m_do  &= ~d;
      5'h09: begin m_pu |= d; m_pd &= ~d; end
      5'h0A: m_pu &= ~d;
      5'h0C: begin m_pd |= d; m_pu &= ~d; end
      5'h0D: m_pd &= ~d;
      5'h0F: m_md |= d;   5'h10: m_md &= ~d;
      5'h12: m_s1 = d;    5'h13: m_s2 = d;   5'h14: m_st = d;
      default: ;
    endcase
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic check_all();
    logic [31:0] v;
    rd(5'h02, v); chk("R1 own", v, m_own);
    rd(5'h05, v); chk("R2 oe", v, m_oe);
    rd(5'h08, v); chk("R2 data", v, m_do);
    rd(5'h11, v); chk("R2 multidrive", v, m_md);
    rd(5'h0B, v); chk("R3 pullup", v, m_pu);
    rd(5'h0E, v); chk("R3 pulldown", v, m_pd);
    chk("R3 pu/pd excl", m_pu & m_pd, 32'h0);
    chk("R3 pad_pu", pad_pu, m_pu);
    chk("R3 pad_pd", pad_pd, m_pd);
    rd(5'h12, v); chk("R4 sel1", v, m_s1);
    rd(5'h13, v); chk("R4 sel2", v, m_s2);
    rd(5'h14, v); chk("R8 stoff", v, m_st);
    chk("R8 pad_st_off", pad_st_off, m_st);
    rd(5'h16 + 5'($urandom_range(0, 9)), v); chk("R10 unmapped", v, 32'h0);
    chk("R5 pad_oe plain", pad_oe & ~m_md, exp_oe() & ~m_md);
    chk("R5 pad_out plain", pad_out & ~m_md, exp_out() & ~m_md);
    chk("R6 pad_oe multidrive", pad_oe & m_md, exp_oe() & m_md);
    chk("R6 pad_out multidrive", pad_out & m_md, exp_out() & m_md);
  endtask

  task automatic rand_periph();
    fa_out = $urandom; fa_oe = $urandom; fb_out = $urandom; fb_oe = $urandom;
    fc_out = $urandom; fc_oe = $urandom; fd_out = $urandom; fd_oe = $urandom;
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    m_own = '1; m_oe = '0; m_do = '0; m_pu = '1; m_pd = '0;
    m_md = '0; m_s1 = '0; m_s2 = '0; m_st = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset values
    rd(5'h02, v); chk("R9 reset own", v, 32'hFFFF_FFFF);
    rd(5'h0B, v); chk("R9 reset pullup", v, 32'hFFFF_FFFF);
    rd(5'h0E, v); chk("R9 reset pulldown", v, 32'h0);
    rd(5'h05, v); chk("R9 reset oe", v, 32'h0);
    chk("R9 reset pad_oe", pad_oe, 32'h0);
    check_all();

    // R3 directed cross-clear
    wr(5'h0C, 32'h0000_F0F0);
    rd(5'h0B, v); chk("R3 pd set clears pu", v, 32'hFFFF_0F0F);
    wr(5'h09, 32'h0000_00F0);
    rd(5'h0E, v); chk("R3 pu set clears pd", v, 32'h0000_F000);

    // R1 zero bits untouched
    wr(5'h01, 32'h0000_000F);
    rd(5'h02, v); chk("R1 clear own low nibble", v, 32'hFFFF_FFF0);

    // R4 walk select codes on pin 0
    fa_out = 32'h0; fa_oe = 32'h1; fb_out = 32'h1; fb_oe = 32'h1;
    fc_out = 32'h0; fc_oe = 32'h0; fd_out = 32'h1; fd_oe = 32'h1;
    wr(5'h12, 32'h0); wr(5'h13, 32'h0);
    chk("R4 code A", {pad_oe[0], pad_out[0]}, 32'h2);
    wr(5'h12, 32'h1);
    chk("R4 code B", {pad_oe[0], pad_out[0]}, 32'h3);
    wr(5'h12, 32'h0); wr(5'h13, 32'h1);
    chk("R4 code C", {pad_oe[0], pad_out[0]}, 32'h0);
    wr(5'h12, 32'h1);
    chk("R4 code D", {pad_oe[0], pad_out[0]}, 32'h3);
    wr(5'h0F, 32'h1);
    chk("R6 D with multidrive released", {pad_oe[0], pad_out[0]}, 32'h0);

    // R10 writes to status addresses ignored
    wr(5'h02, 32'h0); wr(5'h0B, 32'hFFFF_FFFF); wr(5'h15, 32'hFFFF_FFFF);
    check_all();

    // R7 synchronizer latency
    @(negedge clk); pad_in = 32'hA5A5_1234;
    @(negedge clk);
    rd(5'h15, v); chk("R7 level not yet after one edge", v, 32'h0);
    @(negedge clk);
    rd(5'h15, v); chk("R7 level after two edges", v, 32'hA5A5_1234);
    chk("R7 periph_in", periph_in, 32'hA5A5_1234);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      rand_periph();
      wr(5'($urandom_range(0, 31)), $urandom);
      check_all();
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule